// File: doc/BRIEF.md
# ATA Task-File Register Interface

This block is the device-side register file of an ATA-style storage target. A host reaches it through a small bus made of a 4-bit address, a chip select, read and write strobes and 8-bit data. The host writes the transfer parameters: sector count, sector number, the two cylinder bytes and a drive/head byte. The block presents these to the device back end either as a 28-bit logical block address or as a cylinder/head/sector tuple. Bit 6 of the drive/head byte chooses which form is presented.

A write to the command offset hands a command byte to the back end. The back end reports progress through a status load port and raises host interrupts with a one-cycle pulse. The host can read status at two offsets. The main view clears a pending interrupt and the auxiliary view leaves it pending. While the BUSY bit is set, the host cannot issue a new command.

Top module: `tf_regfile`

## Requirements
- R1: Offsets 2, 3, 4 and 5 (sector count, sector number, cylinder low, cylinder high) read back the last byte written to them. A read of an unmapped offset returns 0x00.
- R2: Offset 6 (drive/head) reads back the written byte with bits 7 and 5 forced to 1. Its reset value is 0xA0.
- R3: When drive/head bit 6 is 1, `lba` equals {drive/head[3:0], cylinder high, cylinder low, sector number}, and the three cylinder/head/sector outputs are 0. When bit 6 is 0, `lba` is 0, `chs_cyl` is {cylinder high, cylinder low}, `chs_head` is drive/head[3:0] and `chs_sector` is the sector number.
- R4: Status reads at offset 7 and at offset 0xE return BUSY at bit 7, RDY at bit 6, write fault at bit 5, seek complete at bit 4, DRQ at bit 3, CORR at bit 2 and ERR at bit 0. Bit 1 always reads 0.
- R5: After reset the status is 0x00, so RDY is 0. Status changes only when the device loads a new value through `dev_stat_we`, or when the block sets BUSY on accepting a command.
- R6: A host write to offset 7 while BUSY is 0 is accepted. One clock later `cmd_strobe` is high for exactly one cycle, `cmd_byte` carries the written byte, and BUSY reads 1.
- R7: A host write to offset 7 while BUSY is 1 is ignored. No strobe is issued and the status is unchanged.
- R8: A `dev_irq_pulse` sets a sticky pending flag. A host read of offset 7 clears the flag on the next clock, unless a new pulse arrives in the same cycle, in which case the pulse wins.
- R9: A host read of offset 0xE returns the status and leaves the pending flag unchanged.
- R10: A host write to offset 0xE sets the interrupt mask from data bit 1, where 1 means masked. `host_irq` equals the pending flag while the mask is 0 and is 0 while the mask is 1. The mask is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Host register offset |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from the addressed register |
| host_irq | output | 1 | Interrupt request to the host |
| dev_stat_we | input | 1 | Device status load enable |
| dev_status | input | 8 | Status value to load; bit 1 is discarded |
| dev_irq_pulse | input | 1 | One-cycle interrupt request from the device |
| cmd_strobe | output | 1 | One-cycle pulse marking an accepted command |
| cmd_byte | output | 8 | Last accepted command byte |
| sector_count | output | 8 | Sector count register |
| lba_mode | output | 1 | Drive/head bit 6, 1 selects logical block addressing |
| drive_sel | output | 1 | Drive/head bit 4 |
| lba | output | 28 | Logical block address, valid in block mode |
| chs_cyl | output | 16 | Cylinder number, valid in cylinder/head/sector mode |
| chs_head | output | 4 | Head number, valid in cylinder/head/sector mode |
| chs_sector | output | 8 | Sector number, valid in cylinder/head/sector mode |

## Verification
Several properties are checked on every cycle. Bit 1 of a status read is always 0, and bits 7 and 5 of a drive/head read are always 1. A command write while BUSY is set never produces a strobe. An accepted command always yields the strobe, the byte and BUSY one cycle later. A main status read with no new pulse leaves the interrupt low, an auxiliary read keeps the pending flag, and a set mask holds the interrupt low. Some behaviour can only be shown by the bench's scenarios. These are the exact read-back values after random writes, the address form chosen by the mode bit, the reset values, and the RDY transition driven by a device status load.

// File: rtl/tf_regfile.sv
module tf_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  host_addr,
  input  logic        host_cs,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        host_irq,
  input  logic        dev_stat_we,
  input  logic [7:0]  dev_status,
  input  logic        dev_irq_pulse,
  output logic        cmd_strobe,
  output logic [7:0]  cmd_byte,
  output logic [7:0]  sector_count,
  output logic        lba_mode,
  output logic        drive_sel,
  output logic [27:0] lba,
  output logic [15:0] chs_cyl,
  output logic [3:0]  chs_head,
  output logic [7:0]  chs_sector
);
  localparam logic [3:0] OFF_SCNT = 4'h2;
  localparam logic [3:0] OFF_SNUM = 4'h3;
  localparam logic [3:0] OFF_CYLO = 4'h4;
  localparam logic [3:0] OFF_CYHI = 4'h5;
  localparam logic [3:0] OFF_DRHD = 4'h6;
  localparam logic [3:0] OFF_STAT = 4'h7;
  localparam logic [3:0] OFF_AUX  = 4'hE;
  localparam logic [7:0] DH_FIXED = 8'hA0;
  localparam logic [7:0] ST_MASK  = 8'hFD;

  logic [7:0] scnt_q, snum_q, cylo_q, cyhi_q, drhd_q, status_q, cmd_q;
  logic       irq_pend, irq_mask, strobe_q;

  wire wr_en      = host_cs & host_wr;
  wire rd_en      = host_cs & host_rd;
  wire busy       = status_q[7];
  wire cmd_accept = wr_en && (host_addr == OFF_STAT) && !busy;
  wire main_rd    = rd_en && (host_addr == OFF_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt_q   <= 8'h00;
      snum_q   <= 8'h00;
      cylo_q   <= 8'h00;
      cyhi_q   <= 8'h00;
      drhd_q   <= DH_FIXED;
      status_q <= 8'h00;
      cmd_q    <= 8'h00;
      strobe_q <= 1'b0;
      irq_pend <= 1'b0;
      irq_mask <= 1'b0;
    end else begin
      strobe_q <= cmd_accept;
      if (cmd_accept) cmd_q <= host_wdata;
      if (wr_en) begin
        case (host_addr)
          OFF_SCNT: scnt_q   <= host_wdata;
          OFF_SNUM: snum_q   <= host_wdata;
          OFF_CYLO: cylo_q   <= host_wdata;
          OFF_CYHI: cyhi_q   <= host_wdata;
          OFF_DRHD: drhd_q   <= host_wdata | DH_FIXED;
          OFF_AUX:  irq_mask <= host_wdata[1];
          default: ;
        endcase
      end
      if (dev_stat_we) status_q <= dev_status & ST_MASK;
      if (cmd_accept)  status_q[7] <= 1'b1;
      if (dev_irq_pulse) irq_pend <= 1'b1;
      else if (main_rd)  irq_pend <= 1'b0;
    end
  end

  always_comb begin
    case (host_addr)
      OFF_SCNT: host_rdata = scnt_q;
      OFF_SNUM: host_rdata = snum_q;
      OFF_CYLO: host_rdata = cylo_q;
      OFF_CYHI: host_rdata = cyhi_q;
      OFF_DRHD: host_rdata = drhd_q;
      OFF_STAT,
      OFF_AUX:  host_rdata = status_q;
      default:  host_rdata = 8'h00;
    endcase
  end

  assign host_irq     = irq_pend & ~irq_mask;
  assign cmd_strobe   = strobe_q;
  assign cmd_byte     = cmd_q;
  assign sector_count = scnt_q;
  assign lba_mode     = drhd_q[6];
  assign drive_sel    = drhd_q[4];
  assign lba          = lba_mode ? {drhd_q[3:0], cyhi_q, cylo_q, snum_q} : 28'd0;
  assign chs_cyl      = lba_mode ? 16'd0 : {cyhi_q, cylo_q};
  assign chs_head     = lba_mode ? 4'd0  : drhd_q[3:0];
  assign chs_sector   = lba_mode ? 8'd0  : snum_q;
endmodule

// File: rtl/tf_regfile_chk.sv
module tf_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] host_addr,
  input logic       host_cs,
  input logic       host_rd,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       host_irq,
  input logic       dev_irq_pulse,
  input logic       cmd_strobe,
  input logic [7:0] cmd_byte,
  input logic [7:0] status_q,
  input logic       irq_pend,
  input logic       irq_mask
);
  wire rd_stat = host_cs && host_rd && (host_addr == 4'h7 || host_addr == 4'hE);
  wire cmd_wr  = host_cs && host_wr && host_addr == 4'h7;

  a_r2_dh_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_rd && host_addr == 4'h6) |-> (host_rdata[7] && host_rdata[5]));

  a_r4_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> !host_rdata[1]);

  a_r6_cmd_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !status_q[7]) |=> (cmd_strobe && status_q[7] && cmd_byte == $past(host_wdata)));

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);

  a_r7_busy_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && status_q[7]) |=> !cmd_strobe);

  a_r8_main_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_rd && host_addr == 4'h7 && !dev_irq_pulse) |=> !host_irq);

  a_r8_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq_pulse |=> irq_pend);

  a_r9_aux_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && host_cs && host_rd && host_addr == 4'hE) |=> irq_pend);

  a_r10_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !host_irq);
endmodule

bind tf_regfile tf_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_cs(host_cs),
  .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .host_irq(host_irq), .dev_irq_pulse(dev_irq_pulse),
  .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte), .status_q(status_q),
  .irq_pend(irq_pend), .irq_mask(irq_mask)
);

// File: tb/tf_regfile_tb.sv
module tf_regfile_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0] host_addr = 0;
  logic host_cs = 0, host_rd = 0, host_wr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic host_irq, dev_stat_we = 0, dev_irq_pulse = 0;
  logic [7:0] dev_status = 0;
  logic cmd_strobe, lba_mode, drive_sel;
  logic [7:0] cmd_byte, sector_count, chs_sector;
  logic [27:0] lba;
  logic [15:0] chs_cyl;
  logic [3:0] chs_head;
  int checks = 0, failures = 0;
  logic [7:0] m_reg [2:6];
  logic [7:0] rv;

  tf_regfile u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk); host_cs = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_cs = 0; host_wr = 0;
  endtask

  task automatic hread(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); host_cs = 1; host_rd = 1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk); host_cs = 0; host_rd = 0;
  endtask

  task automatic dstat(logic [7:0] s);
    @(negedge clk); dev_stat_we = 1; dev_status = s;
    @(negedge clk); dev_stat_we = 0;
  endtask

  task automatic dirq();
    @(negedge clk); dev_irq_pulse = 1;
    @(negedge clk); dev_irq_pulse = 0;
  endtask

  function automatic logic [27:0] exp_lba(logic [7:0] dh, logic [7:0] sn, logic [7:0] cl, logic [7:0] ch);
    return dh[6] ? {dh[3:0], ch, cl, sn} : 28'd0;
  endfunction

  function automatic logic [15:0] exp_cyl(logic [7:0] dh, logic [7:0] cl, logic [7:0] ch);
    return dh[6] ? 16'd0 : {ch, cl};
  endfunction

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    hread(4'h7, rv); chk("R5 reset status", rv, 8'h00);
    hread(4'h6, rv); chk("R2 reset drive/head", rv, 8'hA0);
    chk("R10 reset irq", host_irq, 0);
    hread(4'h9, rv); chk("R1 unmapped read", rv, 8'h00);
    for (int i = 2; i <= 6; i++) m_reg[i] = (i == 6) ? 8'hA0 : 8'h00;

    for (int n = 0; n < 300; n++) begin
      logic [3:0] a = 4'(2 + $urandom_range(0, 4));
      logic [7:0] d = 8'($urandom);
      if (n % 50 == 0) d = 8'h40;
      hwrite(a, d);
      m_reg[a] = (a == 4'h6) ? (d | 8'hA0) : d;
      if (n % 3 == 0) begin
        logic [3:0] b = 4'(2 + $urandom_range(0, 4));
        hread(b, rv);
        chk(b == 4'h6 ? "R2 drive/head readback" : "R1 register readback", rv, m_reg[b]);
      end
      chk("R3 lba", lba, exp_lba(m_reg[6], m_reg[3], m_reg[4], m_reg[5]));
      chk("R3 chs cyl", chs_cyl, exp_cyl(m_reg[6], m_reg[4], m_reg[5]));
      chk("R3 chs head", chs_head, m_reg[6][6] ? 4'd0 : m_reg[6][3:0]);
      chk("R3 chs sector", chs_sector, m_reg[6][6] ? 8'd0 : m_reg[3]);
    end
    chk("R1 sector count port", sector_count, m_reg[2]);

    hwrite(4'h6, 8'h4C); hwrite(4'h5, 8'h12); hwrite(4'h4, 8'h34); hwrite(4'h3, 8'h56);
    chk("R3 lba directed", lba, 28'hC123456);
    chk("R3 lba mode", lba_mode, 1);
    hwrite(4'h6, 8'h1B);
    chk("R3 chs directed cyl", chs_cyl, 16'h1234);
    chk("R3 chs directed head", chs_head, 4'hB);
    chk("R2 drive select", drive_sel, 1);
    chk("R3 lba zero in chs", lba, 28'd0);

    dstat(8'hFF); hread(4'hE, rv); chk("R4 bit1 forced 0", rv, 8'hFD);
    dstat(8'h50); hread(4'h7, rv); chk("R5 ready after device load", rv, 8'h50);

    hwrite(4'h7, 8'hEC);
    chk("R6 strobe", cmd_strobe, 1);
    chk("R6 cmd byte", cmd_byte, 8'hEC);
    @(negedge clk); chk("R6 strobe one cycle", cmd_strobe, 0);
    hread(4'h7, rv); chk("R6 busy set", rv, 8'hD0);
    hwrite(4'h7, 8'h20);
    chk("R7 no strobe while busy", cmd_strobe, 0);
    chk("R7 byte kept", cmd_byte, 8'hEC);
    hread(4'h7, rv); chk("R7 status unchanged", rv, 8'hD0);
    dstat(8'h50);
    hwrite(4'h7, 8'h20);
    chk("R6 accepted after busy clears", cmd_byte, 8'h20);

    dirq(); chk("R8 irq set", host_irq, 1);
    hread(4'hE, rv); chk("R9 aux read keeps irq", host_irq, 1);
    hread(4'h7, rv); chk("R8 main read clears irq", host_irq, 0);
    @(negedge clk); host_cs = 1; host_rd = 1; host_addr = 4'h7; dev_irq_pulse = 1;
    @(negedge clk); host_cs = 0; host_rd = 0; dev_irq_pulse = 0;
    chk("R8 pulse wins over read", host_irq, 1);
    hwrite(4'hE, 8'h02); chk("R10 masked", host_irq, 0);
    hwrite(4'hE, 8'h00); chk("R10 unmasked pending", host_irq, 1);
    hread(4'h7, rv); chk("R8 cleared", host_irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule